// File: doc/BRIEF.md
# Serial Mode and Halt Controller

This block sits next to a serial shift engine and decides, cycle by cycle, whether that engine may run. It handles four operating modes: normal running, module disabled, external stop and debug freeze. It takes a module-disable control bit, an external stop request, a debugger halt input, a freeze-enable bit and a debug-active input. It also takes a frame-boundary pulse and an idle flag from the engine. From these it drives a run enable to the engine, a clock-gate enable for the engine's non-register logic, an acknowledge to the power controller, and a gate that causes register and serial accesses to be ignored.

An external stop request and a debug freeze do not take effect in the middle of a frame. They wait for the engine to report a frame boundary. When the engine is idle, that condition counts as already met. Access blocking is different: it starts in the same cycle the stop request arrives. Module disable acts on the next clock edge, wherever the engine is in a frame.

Top module: `serial_mode_ctrl`

## Requirements
- R1: Reset gives mode_o=0 (run), run_en_o=1, clk_en_o=1, stop_ack_o=0 and acc_block_o=0. The mode encoding is 0 run, 1 freeze, 2 stop, 3 disabled.
- R2: Module disable has these effects:
  - While mod_dis_i is high and the block is not in stop, the next cycle shows mode 3, run_en_o=0 and clk_en_o=0.
  - When mod_dis_i is cleared in mode 3, the block is back in run one cycle later.
- R3: A stop request that arrives while the engine is busy and not at a frame boundary leaves the block in run, with stop_ack_o=0.
- R4: A stop request at a frame boundary gives, one cycle later, mode 2, stop_ack_o=1, run_en_o=0 and clk_en_o=0.
- R5: acc_block_o is high in every cycle in which stop_req_i is high, including the cycle of the request itself, and in every cycle spent in stop.
- R6: When stop_req_i is released in stop, the next cycle shows run with stop_ack_o=0.
- R7: A freeze request is dbg_halt_i, frz_en_i and dbg_act_i all high. A freeze request at a frame boundary gives, one cycle later, mode 1 with run_en_o=0, clk_en_o=1 and no access blocking. Without a boundary the block stays in run.
- R8: A debugger halt has no effect when frz_en_i is clear. It also has no effect when dbg_act_i is clear.
- R9: eng_idle_i high counts as a frame boundary, both for a stop request and for a freeze request.
- R10: In freeze, dropping the freeze request returns the block to run on the next cycle.
- R11: Priorities between the modes are fixed:
  - Module disable wins over freeze and over run.
  - Stop wins over freeze at the same boundary.
  - A stop request in freeze moves the block to stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mod_dis_i | input | 1 | Module-disable control bit |
| stop_req_i | input | 1 | External stop request |
| dbg_halt_i | input | 1 | Debugger halt of the system |
| frz_en_i | input | 1 | Freeze on debugger halt enabled |
| dbg_act_i | input | 1 | Debug mode active |
| frame_bnd_i | input | 1 | Engine is at a frame boundary this cycle |
| eng_idle_i | input | 1 | Engine has no frame in progress |
| run_en_o | output | 1 | Engine may run |
| clk_en_o | output | 1 | Clock-gate enable for the engine's non-register logic |
| stop_ack_o | output | 1 | Ready for clocks to be removed |
| acc_block_o | output | 1 | Register and serial accesses are ignored |
| mode_o | output | 2 | Current mode (0 run, 1 freeze, 2 stop, 3 disabled) |

## Verification
A wrong state register shows up at once on mode_o and on the enables. If the block halts early, run_en_o drops in the cycle after a request that came without a boundary. If it ignores the priorities, mode_o shows freeze where disabled or stop was due, exactly one cycle after the competing inputs. A fault in the access gate appears in the same cycle as the stop request, because the gate does not wait for any register.

// File: rtl/serial_mode_pkg.sv
package serial_mode_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN    = 2'd0,
    MODE_FREEZE = 2'd1,
    MODE_STOP   = 2'd2,
    MODE_DIS    = 2'd3
  } mode_e;
endpackage

// File: rtl/serial_mode_qual.sv
module serial_mode_qual (
  input  logic frame_bnd_i,
  input  logic eng_idle_i,
  input  logic dbg_halt_i,
  input  logic frz_en_i,
  input  logic dbg_act_i,
  output logic at_bnd_o,
  output logic frz_req_o
);
  // idle engine: boundary already reached
  assign at_bnd_o  = frame_bnd_i | eng_idle_i;
  assign frz_req_o = dbg_halt_i & frz_en_i & dbg_act_i;
endmodule

// File: rtl/serial_mode_fsm.sv
module serial_mode_fsm
  import serial_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  mod_dis_i,
  input  logic  stop_req_i,
  input  logic  frz_req_i,
  input  logic  at_bnd_i,
  output mode_e mode_o
);
  mode_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      MODE_RUN: begin
        if (mod_dis_i)                  st_d = MODE_DIS;
        else if (stop_req_i && at_bnd_i) st_d = MODE_STOP;
        else if (frz_req_i && at_bnd_i)  st_d = MODE_FREEZE;
      end
      MODE_FREEZE: begin
        // already halted at a boundary
        if (mod_dis_i)       st_d = MODE_DIS;
        else if (stop_req_i) st_d = MODE_STOP;
        else if (!frz_req_i) st_d = MODE_RUN;
      end
      MODE_STOP: begin
        if (!stop_req_i) st_d = MODE_RUN;
      end
      MODE_DIS: begin
        if (!mod_dis_i) st_d = MODE_RUN;
      end
      default: st_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= MODE_RUN;
    else         st_q <= st_d;
  end

  assign mode_o = st_q;

  p_dis_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_dis_i && st_q != MODE_STOP) |=> st_q == MODE_DIS);
  p_dis_exit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == MODE_DIS && !mod_dis_i) |=> st_q == MODE_RUN);
  p_stop_waits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == MODE_RUN && !at_bnd_i) |=> st_q != MODE_STOP && st_q != MODE_FREEZE);
  p_stop_enter_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == MODE_RUN && stop_req_i && at_bnd_i && !mod_dis_i) |=> st_q == MODE_STOP);
  p_stop_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == MODE_STOP && !stop_req_i) |=> st_q == MODE_RUN);
  p_frz_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == MODE_FREEZE && !frz_req_i && !mod_dis_i && !stop_req_i) |=> st_q == MODE_RUN);
  p_frz_prio_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == MODE_FREEZE && mod_dis_i) |=> st_q == MODE_DIS);
endmodule

// File: rtl/serial_mode_out.sv
module serial_mode_out
  import serial_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  stop_req_i,
  output logic  run_en_o,
  output logic  clk_en_o,
  output logic  stop_ack_o,
  output logic  acc_block_o
);
  assign run_en_o    = (mode_i == MODE_RUN);
  assign clk_en_o    = (mode_i == MODE_RUN) || (mode_i == MODE_FREEZE);
  assign stop_ack_o  = (mode_i == MODE_STOP);
  // gate accesses from the request itself, not from the acknowledge
  assign acc_block_o = stop_req_i || (mode_i == MODE_STOP);

  p_ack_clk_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ack_o |-> !clk_en_o && !run_en_o);
  p_ack_blocked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_ack_o) |-> $past(acc_block_o));
  p_one_active_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({run_en_o, stop_ack_o}));
endmodule

// File: rtl/serial_mode_ctrl.sv
module serial_mode_ctrl
  import serial_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mod_dis_i,
  input  logic              stop_req_i,
  input  logic              dbg_halt_i,
  input  logic              frz_en_i,
  input  logic              dbg_act_i,
  input  logic              frame_bnd_i,
  input  logic              eng_idle_i,
  output logic              run_en_o,
  output logic              clk_en_o,
  output logic              stop_ack_o,
  output logic              acc_block_o,
  output logic [MODE_W-1:0] mode_o
);
  logic  at_bnd, frz_req;
  mode_e mode;

  serial_mode_qual u_qual (
    .frame_bnd_i (frame_bnd_i),
    .eng_idle_i  (eng_idle_i),
    .dbg_halt_i  (dbg_halt_i),
    .frz_en_i    (frz_en_i),
    .dbg_act_i   (dbg_act_i),
    .at_bnd_o    (at_bnd),
    .frz_req_o   (frz_req)
  );

  serial_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mod_dis_i  (mod_dis_i),
    .stop_req_i (stop_req_i),
    .frz_req_i  (frz_req),
    .at_bnd_i   (at_bnd),
    .mode_o     (mode)
  );

  serial_mode_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .stop_req_i  (stop_req_i),
    .run_en_o    (run_en_o),
    .clk_en_o    (clk_en_o),
    .stop_ack_o  (stop_ack_o),
    .acc_block_o (acc_block_o)
  );

  assign mode_o = mode;

  p_dbg_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && !mod_dis_i && !stop_req_i && !(frz_en_i && dbg_act_i)) |=> mode_o == 2'd0);
  p_idle_bnd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && !mod_dis_i && stop_req_i && eng_idle_i) |=> stop_ack_o);
endmodule

// File: tb/sim_serial_mode_ctrl.sv
module sim_serial_mode_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [1:0] mode;
    logic       acc;
    string      tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic md = 0, sr = 0, dh = 0, fe = 0, da = 0, fb = 0, idle = 0;
  logic run_en, clk_en, ack, acc;
  logic [1:0] mode;
  int n_chk = 0, n_err = 0;
  exp_t q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_mode_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .mod_dis_i(md), .stop_req_i(sr),
    .dbg_halt_i(dh), .frz_en_i(fe), .dbg_act_i(da), .frame_bnd_i(fb),
    .eng_idle_i(idle), .run_en_o(run_en), .clk_en_o(clk_en),
    .stop_ack_o(ack), .acc_block_o(acc), .mode_o(mode)
  );

  task automatic cmp(input exp_t e);
    logic xr, xc, xa;
    xr = (e.mode == 2'd0);
    xc = (e.mode == 2'd0) || (e.mode == 2'd1);
    xa = (e.mode == 2'd2);
    n_chk++;
    if (mode !== e.mode || run_en !== xr || clk_en !== xc || ack !== xa || acc !== e.acc) begin
      n_err++;
      $display("FAIL %s: mode=%0d run=%b clk=%b ack=%b blk=%b expected mode=%0d run=%b clk=%b ack=%b blk=%b",
               e.tag, mode, run_en, clk_en, ack, acc, e.mode, xr, xc, xa, e.acc);
    end
  endtask

  // driver: inputs held from one negedge to the next; expectation is for after the posedge
  task automatic step(input logic m, s, h, f, a, b, i,
                      input logic [1:0] em, input logic ea, input string t);
    exp_t e;
    @(negedge clk);
    md = m; sr = s; dh = h; fe = f; da = a; fb = b; idle = i;
    e.mode = em; e.acc = ea; e.tag = t;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) cmp(q.pop_front());
    end
  end

  initial begin
    exp_t r;
    #(CLK_PERIOD * 2 + 3);
    r.mode = 2'd0; r.acc = 1'b0; r.tag = "R1 reset";
    cmp(r);
    @(negedge clk) rst_n = 1'b1;
    //   md sr dh fe da fb id  mode acc
    step(0, 0, 0, 0, 0, 0, 0, 2'd0, 0, "R1 run after reset");
    step(0, 1, 0, 0, 0, 0, 0, 2'd0, 1, "R3 R5 request mid-frame");
    step(0, 1, 0, 0, 0, 0, 0, 2'd0, 1, "R3 still waiting");
    step(0, 1, 0, 0, 0, 1, 0, 2'd2, 1, "R4 stop at boundary");
    step(0, 1, 0, 0, 0, 0, 0, 2'd2, 1, "R5 blocked in stop");
    step(0, 0, 0, 0, 0, 0, 0, 2'd0, 0, "R6 stop released");
    step(0, 0, 1, 0, 1, 1, 0, 2'd0, 0, "R8 freeze disabled");
    step(0, 0, 1, 1, 0, 1, 0, 2'd0, 0, "R8 debug inactive");
    step(0, 0, 1, 1, 1, 0, 0, 2'd0, 0, "R7 freeze waits");
    step(0, 0, 1, 1, 1, 1, 0, 2'd1, 0, "R7 freeze at boundary");
    step(0, 0, 1, 1, 1, 0, 0, 2'd1, 0, "R7 freeze held");
    step(0, 0, 0, 1, 1, 0, 0, 2'd0, 0, "R10 halt released");
    step(0, 1, 0, 0, 0, 0, 1, 2'd2, 1, "R9 stop when idle");
    step(0, 0, 0, 0, 0, 0, 0, 2'd0, 0, "R6 back to run");
    step(1, 0, 0, 0, 0, 0, 0, 2'd3, 0, "R2 disable");
    step(1, 0, 1, 1, 1, 1, 0, 2'd3, 0, "R11 disable over freeze");
    step(0, 0, 0, 0, 0, 0, 0, 2'd0, 0, "R2 re-enable");
    step(0, 0, 1, 1, 1, 0, 1, 2'd1, 0, "R9 freeze when idle");
    step(1, 0, 1, 1, 1, 0, 0, 2'd3, 0, "R11 disable leaves freeze");
    step(0, 0, 1, 1, 1, 0, 0, 2'd0, 0, "R2 run, freeze pending");
    step(0, 0, 1, 1, 1, 1, 0, 2'd1, 0, "R7 freeze again");
    step(0, 1, 1, 1, 1, 0, 0, 2'd2, 1, "R11 stop from freeze");
    step(0, 0, 0, 0, 0, 0, 0, 2'd0, 0, "R6 leave stop");
    step(0, 1, 1, 1, 1, 1, 0, 2'd2, 1, "R11 stop over freeze");
    step(0, 0, 0, 0, 0, 0, 0, 2'd0, 0, "R6 final run");
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: done=0 expected done=1");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule